// File: doc/BRIEF.md
# Configurable PCM Serial Audio Transmitter

This block turns a pair of parallel stereo sample words into the three-wire serial stream an external audio DAC expects: a bit clock, a word clock that marks the left and right halves of each frame, and a serial data line. Everything runs from one oversampling clock. The bit clock is derived from it through a programmable divider, so the word rate is the oversampling rate divided by 2 × (1 + divider) × (bits per frame).

Software-visible settings are plain inputs. They are the divider, a slot-size select, a precision code, the bit order, the justification and a mute. A frame holds either two 16-bit slots or two 32-bit slots. Any precision wider than 16 bits forces the wide frame. The sample words and the format settings are captured once per frame, at the frame's first bit. The upstream logic can therefore update them at any time without tearing a slot that is already being sent.

Top module: `pcm_tx`

## Requirements
- R1: The bit clock has a period of 2 × (1 + `divider`) clock cycles, high for (1 + `divider`) cycles and low for (1 + `divider`) cycles.
- R2: A frame lasts 32 bit clocks when `wideSlot` is 0 and `precision` is 0, and 64 bit clocks otherwise (any nonzero precision code forces the 64-bit frame).
- R3: `wordClk` is 0 for the first half of every frame, which carries the left slot, and 1 for the second half, which carries the right slot.
- R4: `sdata` and `wordClk` change only in the clock cycle in which `bitClk` goes from 1 to 0, so they are stable at every rising bit-clock edge.
- R5: Precision codes 0, 1, 2 and 3 select sample words of 16, 18, 20 and 24 bits. A W-bit word is taken from bits [W-1:0] of `leftSample` / `rightSample`.
- R6: With `lsbFirst` = 1 the word is sent least significant bit first; with `lsbFirst` = 0 it is sent most significant bit first.
- R7: With `rightJust` = 0 the word occupies the first W bit positions of its slot; with `rightJust` = 1 it occupies the last W bit positions.
- R8: Slot bit positions not occupied by the sample word carry 0.
- R9: Samples, precision, bit order, justification and frame size are captured at the first bit of each frame. A change in the middle of a frame has no effect on that frame and appears in the next one.
- R10: While `mute` is 1, `sdata` is 0 and the bit and word clocks keep their normal timing.
- R11: During reset, `bitClk`, `wordClk` and `sdata` are 0. The first frame's first bit is driven on the first falling bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divider | input | 8 | Bit-clock divider value |
| wideSlot | input | 1 | 1 selects 32-bit slots (64-bit frame) |
| precision | input | 2 | Sample precision code: 16/18/20/24 bits |
| lsbFirst | input | 1 | 1 sends the least significant bit first |
| rightJust | input | 1 | 1 right-aligns the word in its slot |
| mute | input | 1 | 1 forces the data line to zero |
| leftSample | input | 24 | Left channel sample word |
| rightSample | input | 24 | Right channel sample word |
| bitClk | output | 1 | Serial bit clock |
| wordClk | output | 1 | Word clock: 0 left, 1 right |
| sdata | output | 1 | Serial data |

## Verification
The hardest situation to reach is a sample update that lands inside a slot already being sent, together with the frame size being forced wide by a precision code while `wideSlot` is 0. The bench follows the serial stream by watching bit-clock rises and locks to the frame boundary when the word clock falls. Its capture task then changes the sample inputs at a chosen bit index inside the frame. It checks that the frame in flight still carries the old words and that the following frame carries the new ones. The forced-wide case is driven with the 24-bit precision code and a cleared slot select. The bench checks that the frame counts 64 rising edges and that the word-clock halves fall at 32.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  // Frame position counter: up to 64 bit clocks per frame
  localparam int POS_W = 6;
  localparam int WIDE_FRAME = 64;
  localparam int NARROW_FRAME = 32;

  // Strobes from the timing control to the serializer datapath
  typedef struct packed {
    logic             fall;       // bit clock falls this cycle
    logic             frameStart; // falling edge that begins a frame
    logic [POS_W-1:0] bitPos;     // frame position entered on this fall
    logic             wideFrame;  // frame size of the position entered
  } txStrobe_t;

  // Sample word width for a precision code
  function automatic logic [POS_W-1:0] precWidth(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd18;
      2'd2:    return 6'd20;
      default: return 6'd24;
    endcase
  endfunction
endpackage

// File: rtl/pcm_tx_ctrl.sv
module pcm_tx_ctrl
  import pcm_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divider,
  input  logic             wideReq,
  output logic             bitClk,
  output txStrobe_t        strb
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [POS_W-1:0] LAST_WIDE   = POS_W'(WIDE_FRAME - 1);
  localparam logic [POS_W-1:0] LAST_NARROW = POS_W'(NARROW_FRAME - 1);

  logic [DIV_W-1:0] halfCnt;
  logic             bitClkQ;
  logic [POS_W-1:0] bitCnt;
  logic             wideQ;
  logic             edgeTick;
  logic [POS_W-1:0] lastPos;
  logic [POS_W-1:0] nextPos;

  // A shrinking divider must not strand the counter above its limit
  assign edgeTick = (halfCnt >= divider);
  assign lastPos  = wideQ ? LAST_WIDE : LAST_NARROW;
  assign nextPos  = (bitCnt >= lastPos) ? '0 : bitCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      bitClkQ <= 1'b0;
      bitCnt  <= LAST_NARROW;
      wideQ   <= 1'b0;
    end else if (edgeTick) begin
      halfCnt <= '0;
      bitClkQ <= ~bitClkQ;
      if (bitClkQ) begin
        bitCnt <= nextPos;
        if (nextPos == '0) wideQ <= wideReq;
      end
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  always_comb begin
    strb.fall       = edgeTick & bitClkQ;
    strb.frameStart = edgeTick & bitClkQ & (nextPos == '0);
    strb.bitPos     = nextPos;
    strb.wideFrame  = (nextPos == '0) ? wideReq : wideQ;
  end

  assign bitClk = bitClkQ;

  // R1: the bit clock holds its level while the half-period counter runs
  assert_bitclk_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(halfCnt) < $past(divider)) |-> $stable(bitClkQ));

  // R2: a frame wraps only from its last position for the latched size
  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameStart) |=> ($past(wideQ) ? ($past(bitCnt) == LAST_WIDE)
                                         : ($past(bitCnt) == LAST_NARROW)));
endmodule

// File: rtl/pcm_tx_dp.sv
module pcm_tx_dp
  import pcm_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           strb,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic [1:0]          precision,
  input  logic                lsbFirst,
  input  logic                rightJust,
  input  logic                mute,
  output logic                wordClk,
  output logic                sdata
);
  timeunit 1ns; timeprecision 1ps;

  localparam int IDX_W = $clog2(SAMPLE_W);
  localparam int NUM_CH = 2;

  logic [SAMPLE_W-1:0] chanIn  [NUM_CH];
  logic [SAMPLE_W-1:0] chanQ   [NUM_CH];
  logic [SAMPLE_W-1:0] chanCur [NUM_CH];

  logic [1:0]       precQ;
  logic             lsbQ;
  logic             rjQ;

  logic [1:0]       curPrec;
  logic             curLsb;
  logic             curRj;
  logic [POS_W-1:0] slotBits;
  logic             isRight;
  logic [POS_W-1:0] slotPos;
  logic [POS_W-1:0] wBits;
  logic [POS_W-1:0] startPos;
  logic             inWord;
  logic [POS_W-1:0] offs;
  logic [POS_W-1:0] bitIdx;
  logic [SAMPLE_W-1:0] curWord;
  logic             bitVal;
  logic             wordClkQ;
  logic             sdataQ;

  assign chanIn[0] = leftSample;
  assign chanIn[1] = rightSample;

  // Per-channel capture; the first bit of a frame bypasses the register
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               chanQ[ch] <= '0;
      else if (strb.frameStart) chanQ[ch] <= chanIn[ch];
    end
    assign chanCur[ch] = strb.frameStart ? chanIn[ch] : chanQ[ch];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      precQ <= '0;
      lsbQ  <= 1'b0;
      rjQ   <= 1'b0;
    end else if (strb.frameStart) begin
      precQ <= precision;
      lsbQ  <= lsbFirst;
      rjQ   <= rightJust;
    end
  end

  always_comb begin
    curPrec  = strb.frameStart ? precision : precQ;
    curLsb   = strb.frameStart ? lsbFirst  : lsbQ;
    curRj    = strb.frameStart ? rightJust : rjQ;
    slotBits = strb.wideFrame ? POS_W'(WIDE_FRAME / 2) : POS_W'(NARROW_FRAME / 2);
    isRight  = (strb.bitPos >= slotBits);
    slotPos  = isRight ? (strb.bitPos - slotBits) : strb.bitPos;
    wBits    = precWidth(curPrec);
    startPos = curRj ? (slotBits - wBits) : '0;
    inWord   = (slotPos >= startPos) && (slotPos < (startPos + wBits));
    offs     = slotPos - startPos;
    bitIdx   = curLsb ? offs : (wBits - 1'b1 - offs);
    curWord  = isRight ? chanCur[1] : chanCur[0];
    bitVal   = inWord ? curWord[bitIdx[IDX_W-1:0]] : 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordClkQ <= 1'b0;
      sdataQ   <= 1'b0;
    end else if (strb.fall) begin
      wordClkQ <= isRight;
      sdataQ   <= mute ? 1'b0 : bitVal;
    end
  end

  assign wordClk = wordClkQ;
  assign sdata   = sdataQ;

  // R4: data only moves on a falling bit-clock strobe
  assert_data_on_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.fall) |=> $stable(sdataQ));

  // R10: a muted falling edge always drives zero
  assert_mute_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fall && mute) |=> !sdataQ);

  // R3: the word clock toggles only at a frame or half-frame boundary
  assert_wordclk_half_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(wordClkQ)) |-> ($past(strb.fall) &&
      (($past(strb.bitPos) == 6'd0) || ($past(strb.bitPos) == 6'd16) ||
       ($past(strb.bitPos) == 6'd32))));
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
  import pcm_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  divider,
  input  logic        wideSlot,
  input  logic [1:0]  precision,
  input  logic        lsbFirst,
  input  logic        rightJust,
  input  logic        mute,
  input  logic [23:0] leftSample,
  input  logic [23:0] rightSample,
  output logic        bitClk,
  output logic        wordClk,
  output logic        sdata
);
  timeunit 1ns; timeprecision 1ps;

  localparam int DIV_W    = 8;
  localparam int SAMPLE_W = 24;

  txStrobe_t strb;
  logic      wideReq;

  // Precisions above 16 bits cannot fit a 16-bit slot
  assign wideReq = wideSlot | (precision != 2'd0);

  pcm_tx_ctrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .divider (divider),
    .wideReq (wideReq),
    .bitClk  (bitClk),
    .strb    (strb)
  );

  pcm_tx_dp #(.SAMPLE_W(SAMPLE_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .leftSample  (leftSample),
    .rightSample (rightSample),
    .precision   (precision),
    .lsbFirst    (lsbFirst),
    .rightJust   (rightJust),
    .mute        (mute),
    .wordClk     (wordClk),
    .sdata       (sdata)
  );
endmodule

// File: tb/test_pcm_tx.sv
module test_pcm_tx;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  divider = 8'd1;
  logic        wideSlot = 1'b0;
  logic [1:0]  precision = 2'd0;
  logic        lsbFirst = 1'b0;
  logic        rightJust = 1'b0;
  logic        mute = 1'b0;
  logic [23:0] leftSample = '0;
  logic [23:0] rightSample = '0;
  logic        bitClk;
  logic        wordClk;
  logic        sdata;

  int checks = 0;
  int errors = 0;
  logic bitArr [64];
  logic wcArr  [64];

  pcm_tx i_pcm_tx (
    .clk(clk), .rstN(rstN), .divider(divider), .wideSlot(wideSlot),
    .precision(precision), .lsbFirst(lsbFirst), .rightJust(rightJust),
    .mute(mute), .leftSample(leftSample), .rightSample(rightSample),
    .bitClk(bitClk), .wordClk(wordClk), .sdata(sdata)
  );

  always #2 clk = ~clk; // 250 MHz

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // Returns at the first falling clk edge that sees the bit clock high
  task automatic waitRise(output int cyc);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (bitClk !== 1'b0);
    do begin @(negedge clk); cyc++; end while (bitClk !== 1'b1);
  endtask

  task automatic waitFrameStart();
    int c;
    logic prevWc;
    waitRise(c);
    prevWc = wordClk;
    forever begin
      waitRise(c);
      if (prevWc === 1'b1 && wordClk === 1'b0) break;
      prevWc = wordClk;
    end
  endtask

  function automatic logic expBit(input logic [23:0] s, input int frameLen, input int w,
                                  input logic lsb, input logic rj, input int pos);
    int slot, p, st, k;
    slot = frameLen / 2;
    p = pos % slot;
    st = rj ? slot - w : 0;
    if (p < st || p >= st + w) return 1'b0;
    k = p - st;
    return lsb ? s[k] : s[w-1-k];
  endfunction

  // Capture one frame from its first bit, optionally updating samples mid-frame
  task automatic captureFrame(input string tag, input int frameLen, input int w,
                              input logic lsb, input logic rj, input logic muted,
                              input logic [23:0] expL, input logic [23:0] expR,
                              input int changeAt, input logic [23:0] newL,
                              input logic [23:0] newR);
    int c;
    logic [63:0] gotV, expV;
    logic [3:0] wcOk;
    gotV = '0; expV = '0;
    waitFrameStart();
    for (int i = 0; i < frameLen; i++) begin
      if (i > 0) waitRise(c);
      bitArr[i] = sdata;
      wcArr[i]  = wordClk;
      if (i == changeAt) begin leftSample = newL; rightSample = newR; end
    end
    waitRise(c);
    // R2 and R3: halves of the word clock and the frame length
    wcOk = {wcArr[0], wcArr[frameLen/2-1], wcArr[frameLen/2], wcArr[frameLen-1]};
    check({tag, " R2 R3 word clock shape"}, {59'd0, wcOk, wordClk}, {59'd0, 4'b0011, 1'b0});
    for (int i = 0; i < frameLen; i++) begin
      gotV[63-i] = bitArr[i];
      expV[63-i] = muted ? 1'b0 :
        expBit((i < frameLen/2) ? expL : expR, frameLen, w, lsb, rj, i);
    end
    check({tag, " data bits"}, gotV, expV);
  endtask

  task automatic setCfg(input logic [7:0] dv, input logic ws, input logic [1:0] pr,
                        input logic lsb, input logic rj, input logic [23:0] l,
                        input logic [23:0] r);
    divider = dv; wideSlot = ws; precision = pr; lsbFirst = lsb; rightJust = rj;
    leftSample = l; rightSample = r;
    waitFrameStart();
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {61'd0, bitClk, wordClk, sdata}, 64'd0);
    rstN = 1'b1;
  endtask

  task automatic testPeriod(input logic [7:0] dv);
    int c;
    divider = dv;
    waitRise(c);
    waitRise(c);
    waitRise(c);
    check("R1 bit clock period", 64'(c), 64'(2 * (dv + 1)));
  endtask

  task automatic testNarrowMsb();
    setCfg(8'd1, 1'b0, 2'd0, 1'b0, 1'b0, 24'h00A5C3, 24'h003C96);
    captureFrame("R5 R6 narrow msb-first", 32, 16, 1'b0, 1'b0, 1'b0,
                 24'h00A5C3, 24'h003C96, 99, 0, 0);
  endtask

  task automatic testNarrowLsb();
    setCfg(8'd0, 1'b0, 2'd0, 1'b1, 1'b0, 24'hFF1234, 24'h008001);
    captureFrame("R6 narrow lsb-first", 32, 16, 1'b1, 1'b0, 1'b0,
                 24'hFF1234, 24'h008001, 99, 0, 0);
  endtask

  task automatic testWideRight();
    setCfg(8'd0, 1'b1, 2'd0, 1'b0, 1'b1, 24'hABCDEF, 24'h13579B);
    captureFrame("R7 R8 wide slot right-justified", 64, 16, 1'b0, 1'b1, 1'b0,
                 24'hABCDEF, 24'h13579B, 99, 0, 0);
    setCfg(8'd0, 1'b1, 2'd0, 1'b0, 1'b0, 24'hABCDEF, 24'h13579B);
    captureFrame("R7 R8 wide slot left-justified", 64, 16, 1'b0, 1'b0, 1'b0,
                 24'hABCDEF, 24'h13579B, 99, 0, 0);
  endtask

  task automatic testPrecisions();
    setCfg(8'd0, 1'b0, 2'd3, 1'b0, 1'b0, 24'hC0FFEE, 24'h5A5A5B);
    captureFrame("R2 R5 24-bit forces wide frame", 64, 24, 1'b0, 1'b0, 1'b0,
                 24'hC0FFEE, 24'h5A5A5B, 99, 0, 0);
    setCfg(8'd0, 1'b0, 2'd1, 1'b1, 1'b1, 24'hF3FFFF, 24'h02AAAA);
    captureFrame("R5 R7 18-bit lsb right", 64, 18, 1'b1, 1'b1, 1'b0,
                 24'hF3FFFF, 24'h02AAAA, 99, 0, 0);
    setCfg(8'd0, 1'b1, 2'd2, 1'b0, 1'b1, 24'h9F0F0F, 24'h1EDCBA);
    captureFrame("R5 R8 20-bit msb right", 64, 20, 1'b0, 1'b1, 1'b0,
                 24'h9F0F0F, 24'h1EDCBA, 99, 0, 0);
  endtask

  task automatic testMidFrame();
    setCfg(8'd1, 1'b0, 2'd0, 1'b0, 1'b0, 24'h001111, 24'h002222);
    captureFrame("R9 mid-frame update ignored", 32, 16, 1'b0, 1'b0, 1'b0,
                 24'h001111, 24'h002222, 5, 24'h00EEEE, 24'h00DDDD);
    captureFrame("R9 update seen next frame", 32, 16, 1'b0, 1'b0, 1'b0,
                 24'h00EEEE, 24'h00DDDD, 99, 0, 0);
  endtask

  task automatic testMute();
    setCfg(8'd1, 1'b0, 2'd0, 1'b0, 1'b0, 24'h00FFFF, 24'h00FFFF);
    mute = 1'b1;
    waitFrameStart();
    captureFrame("R10 muted frame", 32, 16, 1'b0, 1'b0, 1'b1,
                 24'h00FFFF, 24'h00FFFF, 99, 0, 0);
    testPeriod(8'd1);
    mute = 1'b0;
  endtask

  initial begin
    testReset();
    testPeriod(8'd1);
    testPeriod(8'd3);
    testPeriod(8'd0);
    testNarrowMsb();
    testNarrowLsb();
    testWideRight();
    testPrecisions();
    testMidFrame();
    testMute();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule